// File: doc/BRIEF.md
# Watch-Mode Power Sequencer

This block tracks the operating mode of a small microcontroller and handles entry to and exit from its deepest clocked low-power state, watch mode. While the CPU is running, a one-cycle sleep strobe is qualified against three control bits and against the current mode. If every condition holds, the sequencer parks the chip in watch mode. In that state only the watchdog keeps its clock.

While in watch mode, the block listens for qualified wake events. Each source is gated by its own enable, and all sources except NMI are also gated by the CPU interrupt mask. On a wake it picks the resume mode from two speed-select inputs. When the resume mode is high-speed or medium-speed, it holds the clocks off for an oscillator settling interval chosen by a 3-bit field. Only after that interval does it fire the strobe that starts interrupt exception processing. Either reset pin returns the chip to high-speed mode. The standby pin drops it from watch mode into hardware standby.

Top module: `pwr_watch_ctrl`

## Requirements
- R1: After `rst_n` is released, `mode_o` is high-speed (code 0), the CPU, peripheral and watchdog clock enables are 1, and `exc_start_o` and `sleep_reject_o` are 0. Mode codes: 0 high-speed, 1 medium-speed, 2 sub-active, 3 watch, 4 hardware standby.
- R2: A sleep strobe taken while the CPU clock is enabled moves the mode to watch at the next edge, provided that:
  - the mode is high-speed or sub-active;
  - `stby_sel_i` is 1, `direct_xfer_i` is 0 and `wdt_presel_i` is 1.
- R3: A sleep strobe taken while the CPU clock is enabled, but with any condition of R2 unmet, leaves the mode unchanged. In that case `sleep_reject_o` is 1 for exactly the following cycle.
- R4: In watch mode, `cpu_clk_en_o` is 0, every bit of `periph_clk_en_o` is 0, and `wdt_clk_en_o` is 1. In hardware standby, all enables are 0.
- R5: In watch mode, a wake is caused by any of the following; with no such event the mode stays watch:
  - `nmi_i`, which is never masked;
  - `irq_i[k]` together with `irq_en_i[k]`, while `cpu_mask_i` is 0;
  - `wdt_ovf_i` together with `wdt_ovf_en_i`, while `cpu_mask_i` is 0.
- R6: On a wake, the next mode is set by the speed-select inputs:
  - sub-active when `low_speed_i` is 1;
  - otherwise medium-speed when `mid_speed_i` is 1;
  - otherwise high-speed.
- R7: On a wake into sub-active mode, `exc_start_o` is 1 in the first sub-active cycle and 0 in the next cycle.
- R8: On a wake into high-speed or medium-speed mode, the CPU and peripheral clock enables stay 0 for 2^(STAB_BASE+`settle_sel_i`) cycles, counted from the first cycle in the new mode. In the cycle at the end of that interval, `exc_start_o` pulses for one cycle and the clocks turn on.
- R9: In watch mode, `standby_n_i` low moves the mode to hardware standby at the next edge, taking priority over any wake. The mode then stays in hardware standby until a reset pin is asserted.
- R10: `sys_rst_n_i` or `man_rst_n_i` low moves the mode to high-speed at the next edge from any state, with priority over everything else. It cancels a pending settling interval without emitting `exc_start_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sleep_i | input | 1 | Sleep strobe from the CPU |
| stby_sel_i | input | 1 | Standby-select control bit |
| direct_xfer_i | input | 1 | Direct-transfer control bit (must be 0 to enter watch) |
| wdt_presel_i | input | 1 | Watchdog prescaler-select control bit |
| low_speed_i | input | 1 | Resume into sub-active mode |
| mid_speed_i | input | 1 | Resume into medium-speed rather than high-speed mode |
| settle_sel_i | input | 3 | Oscillator settling-time select |
| irq_i | input | IRQ_N | External interrupt request lines |
| irq_en_i | input | IRQ_N | Per-line interrupt enables |
| cpu_mask_i | input | 1 | CPU interrupt mask (does not mask NMI) |
| nmi_i | input | 1 | Non-maskable interrupt |
| wdt_ovf_i | input | 1 | Watchdog overflow interrupt request |
| wdt_ovf_en_i | input | 1 | Watchdog overflow interrupt enable |
| sys_rst_n_i | input | 1 | System reset pin, active low |
| man_rst_n_i | input | 1 | Manual reset pin, active low |
| standby_n_i | input | 1 | Hardware standby pin, active low |
| mode_o | output | 3 | Current mode code |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | PERIPH_N | Peripheral clock enables (watchdog excluded) |
| wdt_clk_en_o | output | 1 | Watchdog clock enable |
| exc_start_o | output | 1 | Start strobe for interrupt exception processing |
| sleep_reject_o | output | 1 | Pulse after a sleep strobe whose entry conditions failed |

## Verification
The bench builds the block with STAB_BASE = 2, IRQ_N = 8 and PERIPH_N = 4. This shrinks the settling interval to between 4 and 512 cycles. Every settle-select code can therefore run to completion, many times, inside a few thousand random cycles. Resets landing in the middle of a settling interval, and wakes colliding with the standby pin or with masked lines, are then reached frequently rather than rarely.

// File: rtl/pwr_watch_pkg.sv
package pwr_watch_pkg;

  typedef enum logic [2:0] {
    PM_HIGH   = 3'd0,
    PM_MED    = 3'd1,
    PM_SUB    = 3'd2,
    PM_WATCH  = 3'd3,
    PM_HWSTBY = 3'd4
  } pmode_e;

  // settling length in clocks for a given select code
  function automatic logic [31:0] settle_len(input int unsigned base, input logic [2:0] sel);
    return 32'd1 << (base + 32'(sel));
  endfunction

  // modes in which the CPU may execute
  function automatic logic mode_runs(input pmode_e m);
    return (m == PM_HIGH) || (m == PM_MED) || (m == PM_SUB);
  endfunction

  // modes from which a sleep strobe may enter watch
  function automatic logic entry_mode(input pmode_e m);
    return (m == PM_HIGH) || (m == PM_SUB);
  endfunction

endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual #(
  parameter int IRQ_N = 8
) (
  input  logic [IRQ_N-1:0] irq_i,
  input  logic [IRQ_N-1:0] irq_en_i,
  input  logic             cpu_mask_i,
  input  logic             nmi_i,
  input  logic             wdt_ovf_i,
  input  logic             wdt_ovf_en_i,
  output logic             wake_o
);

  logic [IRQ_N-1:0] line_hit;

  genvar k;
  generate
    for (k = 0; k < IRQ_N; k++) begin : g_line
      assign line_hit[k] = irq_i[k] & irq_en_i[k] & ~cpu_mask_i;
    end
  endgenerate

  logic wdt_hit;
  assign wdt_hit = wdt_ovf_i & wdt_ovf_en_i & ~cpu_mask_i;
  assign wake_o  = (|line_hit) | wdt_hit | nmi_i;

endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer
  import pwr_watch_pkg::*;
#(
  parameter int STAB_BASE = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort_i,
  input  logic       load_i,
  input  logic [2:0] sel_i,
  output logic       busy_o,
  output logic       done_o
);

  localparam int CW = STAB_BASE + 9;

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;
  logic [31:0]   len_full;

  assign len_full = settle_len(unsigned'(STAB_BASE), sel_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (abort_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= len_full[CW-1:0];
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        done_q <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_watch_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_reset_i,
  input  logic   standby_n_i,
  input  logic   sleep_i,
  input  logic   stby_sel_i,
  input  logic   direct_xfer_i,
  input  logic   wdt_presel_i,
  input  logic   low_speed_i,
  input  logic   mid_speed_i,
  input  logic   wake_i,
  input  logic   settle_busy_i,
  output pmode_e mode_o,
  output logic   running_o,
  output logic   settle_load_o,
  output logic   sub_start_o,
  output logic   reject_o,
  output logic   sleep_take_o,
  output logic   wake_take_o
);

  pmode_e mode_q, mode_d;
  logic   sub_start_q, reject_q;
  logic   entry_ok, running;
  logic   load_d, sub_start_d, reject_d, sleep_take_d, wake_take_d;

  assign running  = mode_runs(mode_q) & ~settle_busy_i;
  assign entry_ok = entry_mode(mode_q) & stby_sel_i & ~direct_xfer_i & wdt_presel_i;

  always_comb begin
    mode_d       = mode_q;
    load_d       = 1'b0;
    sub_start_d  = 1'b0;
    reject_d     = 1'b0;
    sleep_take_d = 1'b0;
    wake_take_d  = 1'b0;
    if (pin_reset_i) begin
      mode_d = PM_HIGH;
    end else if (mode_q == PM_WATCH) begin
      if (!standby_n_i) begin
        mode_d = PM_HWSTBY;
      end else if (wake_i) begin
        wake_take_d = 1'b1;
        if (low_speed_i) begin
          mode_d      = PM_SUB;
          sub_start_d = 1'b1;
        end else begin
          mode_d = mid_speed_i ? PM_MED : PM_HIGH;
          load_d = 1'b1;
        end
      end
    end else if (sleep_i && running) begin
      if (entry_ok) begin
        mode_d       = PM_WATCH;
        sleep_take_d = 1'b1;
      end else begin
        reject_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= PM_HIGH;
      sub_start_q <= 1'b0;
      reject_q    <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      sub_start_q <= sub_start_d;
      reject_q    <= reject_d;
    end
  end

  assign mode_o        = mode_q;
  assign running_o     = running;
  assign settle_load_o = load_d;
  assign sub_start_o   = sub_start_q;
  assign reject_o      = reject_q;
  assign sleep_take_o  = sleep_take_d;
  assign wake_take_o   = wake_take_d;

endmodule

// File: rtl/pwr_watch_ctrl.sv
module pwr_watch_ctrl
  import pwr_watch_pkg::*;
#(
  parameter int IRQ_N     = 8,
  parameter int PERIPH_N  = 4,
  parameter int STAB_BASE = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_i,
  input  logic                stby_sel_i,
  input  logic                direct_xfer_i,
  input  logic                wdt_presel_i,
  input  logic                low_speed_i,
  input  logic                mid_speed_i,
  input  logic [2:0]          settle_sel_i,
  input  logic [IRQ_N-1:0]    irq_i,
  input  logic [IRQ_N-1:0]    irq_en_i,
  input  logic                cpu_mask_i,
  input  logic                nmi_i,
  input  logic                wdt_ovf_i,
  input  logic                wdt_ovf_en_i,
  input  logic                sys_rst_n_i,
  input  logic                man_rst_n_i,
  input  logic                standby_n_i,
  output logic [2:0]          mode_o,
  output logic                cpu_clk_en_o,
  output logic [PERIPH_N-1:0] periph_clk_en_o,
  output logic                wdt_clk_en_o,
  output logic                exc_start_o,
  output logic                sleep_reject_o
);

  // named internal events, visible to the bound checker
  logic   pin_reset;
  logic   wake_hit;
  logic   settle_busy;
  logic   settle_done;
  logic   settle_load;
  logic   sub_start;
  logic   running;
  logic   sleep_take;
  logic   wake_take;
  pmode_e mode;

  assign pin_reset = ~sys_rst_n_i | ~man_rst_n_i;

  pwr_wake_qual #(.IRQ_N(IRQ_N)) u_qual (
    .irq_i        (irq_i),
    .irq_en_i     (irq_en_i),
    .cpu_mask_i   (cpu_mask_i),
    .nmi_i        (nmi_i),
    .wdt_ovf_i    (wdt_ovf_i),
    .wdt_ovf_en_i (wdt_ovf_en_i),
    .wake_o       (wake_hit)
  );

  pwr_mode_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .pin_reset_i   (pin_reset),
    .standby_n_i   (standby_n_i),
    .sleep_i       (sleep_i),
    .stby_sel_i    (stby_sel_i),
    .direct_xfer_i (direct_xfer_i),
    .wdt_presel_i  (wdt_presel_i),
    .low_speed_i   (low_speed_i),
    .mid_speed_i   (mid_speed_i),
    .wake_i        (wake_hit),
    .settle_busy_i (settle_busy),
    .mode_o        (mode),
    .running_o     (running),
    .settle_load_o (settle_load),
    .sub_start_o   (sub_start),
    .reject_o      (sleep_reject_o),
    .sleep_take_o  (sleep_take),
    .wake_take_o   (wake_take)
  );

  pwr_settle_timer #(.STAB_BASE(STAB_BASE)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort_i (pin_reset),
    .load_i  (settle_load),
    .sel_i   (settle_sel_i),
    .busy_o  (settle_busy),
    .done_o  (settle_done)
  );

  assign mode_o          = mode;
  assign cpu_clk_en_o    = running;
  assign periph_clk_en_o = {PERIPH_N{running}};
  assign wdt_clk_en_o    = (mode != PM_HWSTBY);
  assign exc_start_o     = settle_done | sub_start;

endmodule

// File: rtl/pwr_watch_chk.sv
module pwr_watch_chk
  import pwr_watch_pkg::*;
#(
  parameter int PERIPH_N = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sys_rst_n_i,
  input logic                man_rst_n_i,
  input logic                standby_n_i,
  input logic                sleep_i,
  input logic                stby_sel_i,
  input logic                direct_xfer_i,
  input logic                wdt_presel_i,
  input logic                low_speed_i,
  input logic [2:0]          mode_o,
  input logic                cpu_clk_en_o,
  input logic [PERIPH_N-1:0] periph_clk_en_o,
  input logic                wdt_clk_en_o,
  input logic                exc_start_o,
  input logic                sleep_reject_o,
  input logic                wake_hit,
  input logic                settle_busy
);

  logic pins_quiet;
  assign pins_quiet = sys_rst_n_i & man_rst_n_i;

  // R2
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_quiet && sleep_i && cpu_clk_en_o &&
     (mode_o == PM_HIGH || mode_o == PM_SUB) &&
     stby_sel_i && !direct_xfer_i && wdt_presel_i) |=> (mode_o == PM_WATCH));

  // R3
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_reject_o |-> (mode_o == $past(mode_o)));

  // R4
  watch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_WATCH) |-> (!cpu_clk_en_o && periph_clk_en_o == '0 && wdt_clk_en_o));

  // R5
  no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_WATCH && !wake_hit && pins_quiet && standby_n_i) |=> (mode_o == PM_WATCH));

  // R6
  sub_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_WATCH && wake_hit && pins_quiet && standby_n_i && low_speed_i)
      |=> (mode_o == PM_SUB && exc_start_o));

  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_start_o |=> !exc_start_o);

  // R8
  settle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settle_busy |-> (!cpu_clk_en_o && !exc_start_o));

  // R9
  hwstby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_WATCH && pins_quiet && !standby_n_i) |=> (mode_o == PM_HWSTBY));

  // R10
  pin_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pins_quiet) |=> (mode_o == PM_HIGH && !exc_start_o && !settle_busy));

endmodule

bind pwr_watch_ctrl pwr_watch_chk #(.PERIPH_N(PERIPH_N)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .sys_rst_n_i     (sys_rst_n_i),
  .man_rst_n_i     (man_rst_n_i),
  .standby_n_i     (standby_n_i),
  .sleep_i         (sleep_i),
  .stby_sel_i      (stby_sel_i),
  .direct_xfer_i   (direct_xfer_i),
  .wdt_presel_i    (wdt_presel_i),
  .low_speed_i     (low_speed_i),
  .mode_o          (mode_o),
  .cpu_clk_en_o    (cpu_clk_en_o),
  .periph_clk_en_o (periph_clk_en_o),
  .wdt_clk_en_o    (wdt_clk_en_o),
  .exc_start_o     (exc_start_o),
  .sleep_reject_o  (sleep_reject_o),
  .wake_hit        (wake_hit),
  .settle_busy     (settle_busy)
);

// File: tb/sim_pwr_watch_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_watch_ctrl;
  localparam int IRQ_N     = 8;
  localparam int PERIPH_N  = 4;
  localparam int STAB_BASE = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, sleep_i, stby_sel, direct_xfer, wdt_presel, low_speed, mid_speed;
  logic [2:0] settle_sel;
  logic [IRQ_N-1:0] irq, irq_en;
  logic cpu_mask, nmi, wdt_ovf, wdt_ovf_en, sys_rst_n, man_rst_n, standby_n;
  logic [2:0] mode_o;
  logic cpu_clk_en, wdt_clk_en, exc_start, sleep_reject;
  logic [PERIPH_N-1:0] periph_clk_en;

  pwr_watch_ctrl #(.IRQ_N(IRQ_N), .PERIPH_N(PERIPH_N), .STAB_BASE(STAB_BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .stby_sel_i(stby_sel),
    .direct_xfer_i(direct_xfer), .wdt_presel_i(wdt_presel), .low_speed_i(low_speed),
    .mid_speed_i(mid_speed), .settle_sel_i(settle_sel), .irq_i(irq), .irq_en_i(irq_en),
    .cpu_mask_i(cpu_mask), .nmi_i(nmi), .wdt_ovf_i(wdt_ovf), .wdt_ovf_en_i(wdt_ovf_en),
    .sys_rst_n_i(sys_rst_n), .man_rst_n_i(man_rst_n), .standby_n_i(standby_n),
    .mode_o(mode_o), .cpu_clk_en_o(cpu_clk_en), .periph_clk_en_o(periph_clk_en),
    .wdt_clk_en_o(wdt_clk_en), .exc_start_o(exc_start), .sleep_reject_o(sleep_reject)
  );

  int vectors = 0;
  int errors  = 0;

  // reference state, written from the requirements
  int   m_mode;
  logic m_busy, m_start, m_rej;
  int   m_left;

  function automatic int exp_len(input logic [2:0] s);
    int n = 1;
    for (int k = 0; k < STAB_BASE + int'(s); k++) n = n * 2;
    return n;
  endfunction

  function automatic logic exp_wake();
    logic masked_src;
    masked_src = ((irq & irq_en) != '0) || (wdt_ovf && wdt_ovf_en);
    return nmi || (!cpu_mask && masked_src);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic run;
    run = (m_mode <= 2) && !m_busy;
    chk("R1 R2 R5 R6 R9 R10 mode", int'(mode_o), m_mode);
    chk("R4 R8 cpu clock", int'(cpu_clk_en), int'(run));
    chk("R4 periph clocks", int'(periph_clk_en), run ? (1 << PERIPH_N) - 1 : 0);
    chk("R4 watchdog clock", int'(wdt_clk_en), (m_mode != 4) ? 1 : 0);
    chk("R7 R8 exc start", int'(exc_start), int'(m_start));
    chk("R3 reject", int'(sleep_reject), int'(m_rej));
  endtask

  task automatic model_step();
    logic run;
    run     = (m_mode <= 2) && !m_busy;
    m_start = 1'b0;
    m_rej   = 1'b0;
    if (!sys_rst_n || !man_rst_n) begin
      m_mode = 0; m_busy = 1'b0; m_left = 0;
    end else begin
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_busy = 1'b0; m_start = 1'b1; end
      end
      if (m_mode == 3) begin
        if (!standby_n) m_mode = 4;
        else if (exp_wake()) begin
          if (low_speed) begin m_mode = 2; m_start = 1'b1; end
          else begin
            m_mode = mid_speed ? 1 : 0;
            m_busy = 1'b1;
            m_left = exp_len(settle_sel);
          end
        end
      end else if (sleep_i && run) begin
        if ((m_mode == 0 || m_mode == 2) && stby_sel && !direct_xfer && wdt_presel) m_mode = 3;
        else m_rej = 1'b1;
      end
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      model_step();
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic quiet();
    sleep_i = 0; irq = '0; nmi = 0; wdt_ovf = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; quiet();
    stby_sel = 1; direct_xfer = 0; wdt_presel = 1; low_speed = 0; mid_speed = 0;
    settle_sel = 0; irq_en = '0; cpu_mask = 0; wdt_ovf_en = 0;
    sys_rst_n = 1; man_rst_n = 1; standby_n = 1;
    m_mode = 0; m_busy = 0; m_left = 0; m_start = 0; m_rej = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare_all();                          // R1 reset state

    // R3: entry bits wrong -> reject
    direct_xfer = 1; sleep_i = 1; tick(); sleep_i = 0; tick(2);
    direct_xfer = 0;
    // R2: enter watch, R4 gating
    sleep_i = 1; tick(); sleep_i = 0; tick(3);
    // R5: disabled line, masked line, disabled watchdog overflow
    irq[3] = 1; tick(2);
    irq_en = 8'h08; cpu_mask = 1; tick(2);
    wdt_ovf = 1; wdt_ovf_en = 0; cpu_mask = 0; irq = '0; tick(2); wdt_ovf = 0;
    // R5 R8: NMI through mask, high-speed resume with select 1
    cpu_mask = 1; settle_sel = 1; nmi = 1; tick(); nmi = 0; cpu_mask = 0;
    tick(exp_len(3'd1) + 3);
    // R6 R7: sub-active resume via enabled line
    sleep_i = 1; tick(); sleep_i = 0; tick();
    low_speed = 1; irq[3] = 1; tick(); irq = '0; tick(3);
    // R9: standby beats wake, holds until reset pin (R10)
    sleep_i = 1; tick(); sleep_i = 0; tick();
    standby_n = 0; nmi = 1; tick(); standby_n = 1; tick(3); nmi = 0; tick(2);
    man_rst_n = 0; tick(); man_rst_n = 1; tick(2);
    // R10: reset pin cancels medium-speed settling
    low_speed = 0; mid_speed = 1; settle_sel = 2;
    sleep_i = 1; tick(); sleep_i = 0; tick();
    wdt_ovf = 1; wdt_ovf_en = 1; tick(); wdt_ovf = 0; tick(5);
    sys_rst_n = 0; tick(); sys_rst_n = 1; tick(exp_len(3'd2) + 2);

    // constrained random
    for (int c = 0; c < 5000; c++) begin
      sleep_i     = ($urandom % 5) == 0;
      stby_sel    = ($urandom % 8) != 0;
      direct_xfer = ($urandom % 8) == 0;
      wdt_presel  = ($urandom % 8) != 0;
      low_speed   = ($urandom % 3) == 0;
      mid_speed   = $urandom % 2;
      settle_sel  = 3'($urandom % 8);
      irq         = (($urandom % 12) == 0) ? IRQ_N'(1 << ($urandom % IRQ_N)) : '0;
      irq_en      = IRQ_N'($urandom);
      cpu_mask    = ($urandom % 4) == 0;
      nmi         = ($urandom % 80) == 0;
      wdt_ovf     = ($urandom % 30) == 0;
      wdt_ovf_en  = $urandom % 2;
      sys_rst_n   = ($urandom % 300) != 0;
      man_rst_n   = ($urandom % 300) != 0;
      standby_n   = ($urandom % 60) != 0;
      tick();
    end
    summary();
    $finish;
  end
endmodule